// File: doc/BRIEF.md
# Power-Down Entry and Restart Sequencer

This block sits beside a small microcontroller core. It watches the core's decoded instruction strobes and decides when the core enters low power. There are two low-power states. In the clock-operating state the main clock is stopped and the sub-clock keeps running. In RAM back-up both clocks are stopped. Either state is entered only through a two-instruction sequence: an enable instruction, then a power-off or deep power-off instruction in the very next cycle.

While the core sleeps, the block waits for a wake event. It then asks the stabilization timer for a settling period and keeps the core held until that timer reports done. When the core restarts, a sticky power-down flag and the timer underflow flag decide the restart cause. A cleared flag means a cold start. A set flag means a warm start, which is caused either by a timer underflow or by the external wakeup input. The cause stays visible until the next power-down entry or reset.

Top module: `pwrdn_restart_seq`

## Requirements
- R1: After reset the block is in running state (powerState 0), pdFlag is 0, restartCause is 1 (cold), both clock enables are 1, and coreHold and stabReq are 0.
- R2: A retired enable instruction, followed in the next cycle by a retired power-off instruction, moves the block to clock-operating state (powerState 1) at that edge. mainClkEn is then 0, subClkEn is 1 and coreHold is 1.
- R3: A retired enable instruction, followed in the next cycle by a retired deep power-off instruction, moves the block to RAM back-up (powerState 2). Both clock enables are then 0.
- R4: Arming lasts one cycle only. In the cycle after the enable instruction, an idle cycle, any other retired instruction, or an enable strobe without instrRetire each leave the block not armed. A power-off instruction without arming leaves the block running.
- R5: pdFlag is set at entry to either low-power state and stays 1 through wakeup and restart. Only reset clears it.
- R6: In clock-operating state, timerUnderflow or extWake moves the block to the stabilizing state (powerState 3). In RAM back-up only extWake does this, and timerUnderflow is ignored. In stabilizing state stabReq is 1, both clock enables are 1 and coreHold is 1.
- R7: The block stays in stabilizing state until stabDone is 1, and at that edge returns to running. stabDone has no effect in any other state.
- R8: At restart, restartCause becomes 2 (warm, timer) if pdFlag and timerUnderflow are both 1 at the stabDone edge. It becomes 3 (warm, external) if pdFlag is 1 and timerUnderflow is 0, and 1 (cold) if pdFlag is 0. It reads 0 from power-down entry until restart, and it holds its value while running.
- R9: While the block is not running, instruction strobes have no effect.
- R10: subClkEn is 0 only in RAM back-up. coreHold is 1 in every state except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrRetire | input | 1 | Core retired an instruction this cycle |
| opEnable | input | 1 | Retired instruction is the power-off enable |
| opPowerOff | input | 1 | Retired instruction is power-off (clocks: sub only) |
| opDeepOff | input | 1 | Retired instruction is deep power-off (no clocks) |
| timerUnderflow | input | 1 | Timer underflow flag from the core's timer |
| extWake | input | 1 | External wakeup event |
| stabDone | input | 1 | Stabilization timer finished counting |
| stabReq | output | 1 | Request to the stabilization timer |
| coreHold | output | 1 | Keep the core stopped |
| mainClkEn | output | 1 | Main oscillator enable |
| subClkEn | output | 1 | Sub-clock oscillator enable |
| pdFlag | output | 1 | Sticky power-down flag |
| powerState | output | 2 | 0 running, 1 clock-operating, 2 RAM back-up, 3 stabilizing |
| restartCause | output | 2 | 0 none, 1 cold, 2 warm timer, 3 warm external |

## Verification
The hardest situation to reach from the ports is a power-off instruction that arrives just after the arming has lapsed. The enable must be seen, then lost to an idle cycle, to a different instruction, or to an enable strobe without a retire, and only then followed by the power-off. The vector table places each of these gaps directly in front of a power-off strobe and checks that the block stays running. It then repeats the exact back-to-back pair to show that entry still works. Timer underflow pulses during RAM back-up, and stray done pulses outside stabilization, are also applied to show that they have no effect.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_CLKOP  = 2'd1,
    PS_BACKUP = 2'd2,
    PS_STAB   = 2'd3
  } pwrState_e;

  typedef enum logic [1:0] {
    RC_NONE  = 2'd0,
    RC_COLD  = 2'd1,
    RC_TIMER = 2'd2,
    RC_EXT   = 2'd3
  } restartCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setFlag;     // low-power entry taken
    logic clearCause;  // blank the restart cause on entry
    logic latchCause;  // capture the restart cause on return
  } ctlStrobe_t;

endpackage

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrRetire,
  input  logic       opEnable,
  input  logic       opPowerOff,
  input  logic       opDeepOff,
  input  logic       timerUnderflow,
  input  logic       extWake,
  input  logic       stabDone,
  output pwrState_e  state,
  output ctlStrobe_t strobe
);

  pwrState_e stateNext;
  logic      armed;
  logic      armedNext;
  logic      running;
  logic      enterClkOp;
  logic      enterBackup;

  assign running     = (state == PS_RUN);
  // arming survives exactly one cycle
  assign armedNext   = running & instrRetire & opEnable;
  assign enterBackup = running & armed & instrRetire & opDeepOff;
  assign enterClkOp  = running & armed & instrRetire & opPowerOff & ~opDeepOff;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      PS_RUN: begin
        if (enterBackup) begin
          stateNext         = PS_BACKUP;
          strobe.setFlag    = 1'b1;
          strobe.clearCause = 1'b1;
        end else if (enterClkOp) begin
          stateNext         = PS_CLKOP;
          strobe.setFlag    = 1'b1;
          strobe.clearCause = 1'b1;
        end
      end
      PS_CLKOP: begin
        if (timerUnderflow || extWake) stateNext = PS_STAB;
      end
      PS_BACKUP: begin
        // timer is unclocked here; only the external pin wakes
        if (extWake) stateNext = PS_STAB;
      end
      PS_STAB: begin
        if (stabDone) begin
          stateNext         = PS_RUN;
          strobe.latchCause = 1'b1;
        end
      end
      default: stateNext = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_RUN;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      armed <= armedNext;
    end
  end

endmodule

// File: rtl/pwrdn_datapath.sv
module pwrdn_datapath
  import pwrdn_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          timerUnderflow,
  output logic          pdFlag,
  output restartCause_e cause
);

  restartCause_e warmCause;

  assign warmCause = timerUnderflow ? RC_TIMER : RC_EXT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdFlag <= 1'b0;
      cause  <= RC_COLD;
    end else begin
      if (strobe.setFlag) pdFlag <= 1'b1;
      if (strobe.clearCause) begin
        cause <= RC_NONE;
      end else if (strobe.latchCause) begin
        cause <= pdFlag ? warmCause : RC_COLD;
      end
    end
  end

endmodule

// File: rtl/pwrdn_clk_decode.sv
module pwrdn_clk_decode
  import pwrdn_pkg::*;
(
  input  pwrState_e state,
  output logic      mainClkEn,
  output logic      subClkEn,
  output logic      coreHold,
  output logic      stabReq
);

  always_comb begin
    mainClkEn = 1'b1;
    subClkEn  = 1'b1;
    coreHold  = 1'b1;
    stabReq   = 1'b0;
    unique case (state)
      PS_RUN:    coreHold  = 1'b0;
      PS_CLKOP:  mainClkEn = 1'b0;
      PS_BACKUP: begin
        mainClkEn = 1'b0;
        subClkEn  = 1'b0;
      end
      PS_STAB:   stabReq   = 1'b1;
      default:   coreHold  = 1'b1;
    endcase
  end

endmodule

// File: rtl/pwrdn_restart_seq.sv
module pwrdn_restart_seq
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrRetire,
  input  logic       opEnable,
  input  logic       opPowerOff,
  input  logic       opDeepOff,
  input  logic       timerUnderflow,
  input  logic       extWake,
  input  logic       stabDone,
  output logic       stabReq,
  output logic       coreHold,
  output logic       mainClkEn,
  output logic       subClkEn,
  output logic       pdFlag,
  output logic [1:0] powerState,
  output logic [1:0] restartCause
);

  pwrState_e     state;
  ctlStrobe_t    strobe;
  restartCause_e cause;

  pwrdn_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .instrRetire    (instrRetire),
    .opEnable       (opEnable),
    .opPowerOff     (opPowerOff),
    .opDeepOff      (opDeepOff),
    .timerUnderflow (timerUnderflow),
    .extWake        (extWake),
    .stabDone       (stabDone),
    .state          (state),
    .strobe         (strobe)
  );

  pwrdn_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .timerUnderflow (timerUnderflow),
    .pdFlag         (pdFlag),
    .cause          (cause)
  );

  pwrdn_clk_decode u_dec (
    .state     (state),
    .mainClkEn (mainClkEn),
    .subClkEn  (subClkEn),
    .coreHold  (coreHold),
    .stabReq   (stabReq)
  );

  assign powerState   = state;
  assign restartCause = cause;

endmodule

// File: rtl/pwrdn_restart_seq_chk.sv
module pwrdn_restart_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timerUnderflow,
  input logic       extWake,
  input logic       stabDone,
  input logic       stabReq,
  input logic       coreHold,
  input logic       mainClkEn,
  input logic       subClkEn,
  input logic       pdFlag,
  input logic [1:0] powerState,
  input logic [1:0] restartCause
);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    pdFlag |=> pdFlag);

  a_r2_entry_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerState) == 2'd0 && powerState != 2'd0) |-> pdFlag);

  a_r3_backup_clocks_off: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd2) |-> (!mainClkEn && !subClkEn));

  a_r6_backup_ignores_timer: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd2 && !extWake) |=> powerState == 2'd2);

  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd3 && !stabDone) |=> (powerState == 2'd3 && stabReq && coreHold));

  a_r7_done_resumes: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd3 && stabDone) |=> (powerState == 2'd0 && !coreHold));

  a_r8_warm_cause: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd3 && stabDone && pdFlag) |=>
      restartCause == ($past(timerUnderflow) ? 2'd2 : 2'd3));

  a_r8_none_while_down: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == 2'd1 || powerState == 2'd2) |-> restartCause == 2'd0);

  a_r10_hold_outside_run: assert property (@(posedge clk) disable iff (!rstN)
    (powerState != 2'd0) |-> coreHold);

endmodule

bind pwrdn_restart_seq pwrdn_restart_seq_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .timerUnderflow (timerUnderflow),
  .extWake        (extWake),
  .stabDone       (stabDone),
  .stabReq        (stabReq),
  .coreHold       (coreHold),
  .mainClkEn      (mainClkEn),
  .subClkEn       (subClkEn),
  .pdFlag         (pdFlag),
  .powerState     (powerState),
  .restartCause   (restartCause)
);

// File: tb/pwrdn_restart_seq_tb.sv
module pwrdn_restart_seq_tb;

  typedef struct packed {
    logic       ret;
    logic       en;
    logic       off;
    logic       deep;
    logic       tmr;
    logic       ext;
    logic       done;
    logic [1:0] st;
    logic       flag;
    logic [1:0] cause;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    // ret en off deep tmr ext done | st flag cause | req
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd1},  // R1 idle instr
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd4},  // R4 unarmed off
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd4},  // arm
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd4},  // R4 other instr
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd4},  // R4 off too late
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,2'd1, 4'd2},  // arm
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,1'b1,2'd0, 4'd2},  // R2 entry
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1,1'b1,2'd0, 4'd6},  // R6 no event
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1,1'b1,2'd0, 4'd9},  // R9 arm while down
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1,1'b1,2'd0, 4'd9},  // R9 deep while down
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd3,1'b1,2'd0, 4'd6},  // R6 timer wakes
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd3,1'b1,2'd0, 4'd7},  // R7 waiting
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,1'b1,2'd2, 4'd8},  // R8 warm timer
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd2, 4'd8},  // R8 cause held
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd2,1'b1,2'd0, 4'd3},  // R3 backup
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd2,1'b1,2'd0, 4'd6},  // R6 timer ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd2,1'b1,2'd0, 4'd7},  // R7 stray done
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd3,1'b1,2'd0, 4'd6},  // R6 ext wakes
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,1'b1,2'd3, 4'd8},  // R8 warm ext
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd4},  // arm
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd4},  // R4 idle gap
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd4},  // R4 off after gap
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd4},  // enable not retired
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd4},  // R4 deep unarmed
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,2'd3, 4'd2},  // arm
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,1'b1,2'd0, 4'd2},  // R2 second entry
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd3,1'b1,2'd0, 4'd6},  // R6 ext from clkop
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,1'b1,2'd2, 4'd8}   // R8 timer at done
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrRetire = 1'b0, opEnable = 1'b0, opPowerOff = 1'b0, opDeepOff = 1'b0;
  logic       timerUnderflow = 1'b0, extWake = 1'b0, stabDone = 1'b0;
  logic       stabReq, coreHold, mainClkEn, subClkEn, pdFlag;
  logic [1:0] powerState, restartCause;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pwrdn_restart_seq u_dut (
    .clk(clk), .rstN(rstN), .instrRetire(instrRetire), .opEnable(opEnable),
    .opPowerOff(opPowerOff), .opDeepOff(opDeepOff), .timerUnderflow(timerUnderflow),
    .extWake(extWake), .stabDone(stabDone), .stabReq(stabReq), .coreHold(coreHold),
    .mainClkEn(mainClkEn), .subClkEn(subClkEn), .pdFlag(pdFlag),
    .powerState(powerState), .restartCause(restartCause)
  );

  task automatic drive(input logic r, e, o, d, t, x, dn);
    instrRetire = r; opEnable = e; opPowerOff = o; opDeepOff = d;
    timerUnderflow = t; extWake = x; stabDone = dn;
  endtask

  // expected side outputs derive from state per R6/R10/R2/R3
  task automatic checkAll(input string tag, input logic [1:0] st, input logic fl,
                          input logic [1:0] ca);
    logic [7:0] act, exp;
    act = {powerState, pdFlag, restartCause, mainClkEn, subClkEn, coreHold};
    exp = {st, fl, ca, (st == 2'd0 || st == 2'd3), (st != 2'd2), (st != 2'd0)};
    nChecks++;
    if (act !== exp || stabReq !== (st == 2'd3)) begin
      nFails++;
      $display("FAIL %s: act st/flag/cause/main/sub/hold=%b stab=%b exp %b stab=%b",
               tag, act, stabReq, exp, (st == 2'd3));
    end
  endtask

  task automatic step(input logic r, e, o, d, t, x, dn);
    @(negedge clk);
    drive(r, e, o, d, t, x, dn);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: act hung exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset", 2'd0, 1'b0, 2'd1);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ret, VECS[i].en, VECS[i].off, VECS[i].deep,
           VECS[i].tmr, VECS[i].ext, VECS[i].done);
      checkAll($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].st, VECS[i].flag, VECS[i].cause);
    end

    // R5: reset during stabilization clears the flag, cause back to cold (R1)
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    checkAll("R6 wake before reset", 2'd3, 1'b1, 2'd0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b0;
    #1;
    checkAll("R5 reset clears flag", 2'd0, 1'b0, 2'd1);
    @(negedge clk);
    rstN = 1'b1;

    // R3 then R8 warm external from backup
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    checkAll("R3 backup again", 2'd2, 1'b1, 2'd0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    checkAll("R7 hold without done", 2'd3, 1'b1, 2'd0);
    step(0, 0, 0, 0, 0, 0, 1);
    checkAll("R8 warm external", 2'd0, 1'b1, 2'd3);
    step(1, 0, 1, 0, 0, 0, 0);
    checkAll("R4 R5 unarmed off keeps run", 2'd0, 1'b1, 2'd3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule